// File: doc/BRIEF.md
# Read-Latency Training Sequencer

This block runs the start-up training of a source-synchronous SRAM read path. After a start pulse it takes the memory address, command and write-data lines away from the normal controller and holds that controller paused. It then waits for the delay-locked loop to report lock. It issues a read-pointer alignment pulse to the resynchronization buffer, and after that a write-pointer reset pulse. It writes a known pattern to one fixed training address while reading that same address in the same cycle. It then counts cycles until the pattern comes back on the read-data input.

Returned data in the first few cycles after the write/read cannot be valid, so a match there is ignored. The measured round trip is compared with a fixed target latency. If it is no larger than the target, the block reports done and gives a one-cycle adjust command carrying the pointer offset, which is the target minus the measurement. The resynchronization buffer uses that offset so that every device ends up with the same known read latency. If the measurement is larger than the target, or no match arrives inside the timeout window, the block reports failure. In both cases the memory lines go back to the controller.

Top module: `rdlat_trainer`

## Requirements
- R1: After reset the block is idle. Busy, done, fail, pause, the alignment pulse, the reset pulse and the adjust pulse are all low, and the reported latency is 0.
- R2: When the block is not training (idle, done or failed), the memory address, write, read and write-data outputs equal the controller's inputs in the same cycle.
- R3: From the start pulse until the result, busy and controller pause are high. In that window the memory address output is the training address (default 0x5A), whatever the controller drives.
- R4: The read-pointer alignment pulse comes only after the DLL-locked input has been sampled high. While that input stays low, training waits and issues no alignment.
- R5: Each run gives exactly one read-pointer alignment pulse and one write-pointer reset pulse. The reset pulse comes in the cycle directly after the alignment pulse.
- R6: Each run has exactly one cycle with memory write and read both high. In that cycle the address is the training address and the write data is the pattern (default 0xA5C3).
- R7: The measured latency L is the number of clock edges from the write/read cycle until the first cycle in which the read-data input equals the pattern, with L > BLANK (default 2). Pattern matches at L ≤ BLANK are ignored. On success or on a late match the status reports L. On a timeout it reports 0.
- R8: If BLANK < L ≤ TARGET_LAT (default 12), the block reaches done. The adjust output then carries TARGET_LAT − L, and the adjust-valid line is high for exactly one cycle, in the first done cycle.
- R9: If L > TARGET_LAT, or no valid match arrives by count TIMEOUT (default 64), the block reaches fail and issues no adjust pulse.
- R10: A start pulse that arrives while training is busy is ignored. The run's pulses and its result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a training run when not busy |
| dll_locked | input | 1 | DLL stable indication |
| ctl_addr | input | ADDR_W | Controller address |
| ctl_wr | input | 1 | Controller write command |
| ctl_rd | input | 1 | Controller read command |
| ctl_wdata | input | DATA_W | Controller write data |
| rd_data | input | DATA_W | Resynchronized read data returned from memory |
| mem_addr | output | ADDR_W | Address to memory I/O |
| mem_wr | output | 1 | Write command to memory I/O |
| mem_rd | output | 1 | Read command to memory I/O |
| mem_wdata | output | DATA_W | Write data to memory I/O |
| ctl_pause | output | 1 | Holds the normal controller paused |
| rd_ptr_align | output | 1 | Read-pointer alignment pulse to the resync buffer |
| wr_ptr_rst | output | 1 | Write-pointer reset pulse to the resync buffer |
| adj_vld | output | 1 | Pointer-offset command valid (one cycle) |
| adj_off | output | LAT_W | Pointer offset, TARGET_LAT minus measured latency |
| trn_busy | output | 1 | Training in progress |
| trn_done | output | 1 | Training succeeded |
| trn_fail | output | 1 | Training failed |
| trn_lat | output | LAT_W | Measured round-trip latency |

## Verification
The bench sweeps the round-trip delay of a memory model from 1 to 70 cycles. This covers the ignored window, the valid range up to the target, the late range up to the timeout, and delays beyond the timeout, so the offset arithmetic and both fail causes are told apart at every boundary. On alternate delays the model also returns the pattern early, inside the blank window, which tells a block that honours the blank window from one that stops on the first match. The DLL-lock delay varies across runs to separate waiting on lock from running ahead of it. One run has a second start pulse mid-training, to show that restarts are ignored while busy.

// File: rtl/rdlat_pkg.sv
// Package: shared state encoding for the read-latency training sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package rdlat_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DLLW  = 3'd1,
        ST_ALRD  = 3'd2,
        ST_RSWR  = 3'd3,
        ST_WPAT  = 3'd4,
        ST_MEAS  = 3'd5,
        ST_DONE  = 3'd6,
        ST_FAIL  = 3'd7
    } trn_state_e;

endpackage

// File: rtl/rdlat_meter.sv
// Module: rdlat_meter
// Counts round-trip cycles after the training write/read and flags the first
// valid pattern match, or a timeout.
// Assumes: arm is high for one cycle (the write/read cycle), and measuring is
// high on the following cycles until the sequencer leaves measurement.
module rdlat_meter #(
    parameter int DATA_W  = 16,
    parameter int TIMEOUT = 64,
    parameter int BLANK   = 2,
    parameter logic [DATA_W-1:0] PATTERN = 16'hA5C3,
    localparam int LAT_W  = $clog2(TIMEOUT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              measuring,
    input  logic [DATA_W-1:0] rd_data,
    output logic              hit,
    output logic              expire,
    output logic [LAT_W-1:0]  count
);

    localparam logic [LAT_W-1:0] BLANK_C = LAT_W'(BLANK);
    localparam logic [LAT_W-1:0] LIMIT_C = LAT_W'(TIMEOUT);

    logic [LAT_W-1:0] cnt_q;

    // Round-trip counter: 1 in the first measuring cycle, saturating at TIMEOUT.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (arm) begin
            cnt_q <= LAT_W'(1);
        end else if (measuring && !hit && cnt_q < LIMIT_C) begin
            cnt_q <= cnt_q + LAT_W'(1);
        end
    end

    // Match detect: only past the blank window where data cannot be valid yet.
    always_comb begin
        hit    = measuring && (cnt_q > BLANK_C) && (rd_data == PATTERN);
        expire = measuring && !hit && (cnt_q >= LIMIT_C);
        count  = cnt_q;
    end

    // R9
    cnt_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        measuring |-> (cnt_q >= LAT_W'(1) && cnt_q <= LIMIT_C));

    // R7
    cnt_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (cnt_q == LAT_W'(1)));

endmodule

// File: rtl/rdlat_seq.sv
// Module: rdlat_seq
// Training state machine: DLL wait, pointer alignment and reset pulses,
// pattern write/read, measurement and result/offset registers.
// Assumes: TARGET_LAT < TIMEOUT, and the hit/expire inputs come from the meter.
module rdlat_seq
    import rdlat_pkg::*;
#(
    parameter int TIMEOUT    = 64,
    parameter int TARGET_LAT = 12,
    localparam int LAT_W     = $clog2(TIMEOUT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dll_locked,
    input  logic             hit,
    input  logic             expire,
    input  logic [LAT_W-1:0] count,
    output logic             own_io,
    output logic             arm,
    output logic             measuring,
    output logic             rd_ptr_align,
    output logic             wr_ptr_rst,
    output logic             adj_vld,
    output logic [LAT_W-1:0] adj_off,
    output logic             trn_done,
    output logic             trn_fail,
    output logic [LAT_W-1:0] trn_lat
);

    localparam logic [LAT_W-1:0] TARGET_C = LAT_W'(TARGET_LAT);

    trn_state_e       st_q, st_d;
    logic [LAT_W-1:0] lat_q, off_q;
    logic             adj_q;

    // Next-state decode for the training sequence.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE, ST_DONE, ST_FAIL: if (start) st_d = ST_DLLW;
            ST_DLLW: if (dll_locked) st_d = ST_ALRD;
            ST_ALRD: st_d = ST_RSWR;
            ST_RSWR: st_d = ST_WPAT;
            ST_WPAT: st_d = ST_MEAS;
            ST_MEAS: begin
                if (hit)         st_d = (count > TARGET_C) ? ST_FAIL : ST_DONE;
                else if (expire) st_d = ST_FAIL;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Result registers: latency, offset and a one-cycle adjust strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
            off_q <= '0;
            adj_q <= 1'b0;
        end else begin
            adj_q <= 1'b0;
            if (st_q != ST_MEAS && st_d == ST_DLLW) begin
                lat_q <= '0;
                off_q <= '0;
            end else if (st_q == ST_MEAS && hit) begin
                lat_q <= count;
                if (count <= TARGET_C) begin
                    off_q <= TARGET_C - count;
                    adj_q <= 1'b1;
                end
            end
        end
    end

    // Output decode from the registered state.
    always_comb begin
        own_io       = (st_q == ST_DLLW) || (st_q == ST_ALRD) || (st_q == ST_RSWR)
                    || (st_q == ST_WPAT) || (st_q == ST_MEAS);
        arm          = (st_q == ST_WPAT);
        measuring    = (st_q == ST_MEAS);
        rd_ptr_align = (st_q == ST_ALRD);
        wr_ptr_rst   = (st_q == ST_RSWR);
        trn_done     = (st_q == ST_DONE);
        trn_fail     = (st_q == ST_FAIL);
        adj_vld      = adj_q;
        adj_off      = off_q;
        trn_lat      = lat_q;
    end

    // R4
    align_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr_align |-> $past(dll_locked));

    // R5
    wr_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr_align |=> wr_ptr_rst);

    // R5
    wr_needs_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_ptr_rst) |-> $past(rd_ptr_align));

    // R8
    adj_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adj_vld |-> (trn_done && adj_off == TARGET_C - trn_lat));

    // R8
    adj_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adj_vld |=> !adj_vld);

    // R9
    fail_no_adj_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trn_fail |-> !adj_vld);

    // R1
    one_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({own_io, trn_done, trn_fail}));

endmodule

// File: rtl/rdlat_iomux.sv
// Module: rdlat_iomux
// Selects the memory I/O lines: training values while training owns the I/O,
// otherwise the controller's lines, combinationally.
// Assumes: own_io is a registered decode, so the select is glitch-free per cycle.
module rdlat_iomux #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter logic [ADDR_W-1:0] TRAIN_ADDR = 8'h5A,
    parameter logic [DATA_W-1:0] PATTERN    = 16'hA5C3
) (
    input  logic              own_io,
    input  logic              arm,
    input  logic [ADDR_W-1:0] ctl_addr,
    input  logic              ctl_wr,
    input  logic              ctl_rd,
    input  logic [DATA_W-1:0] ctl_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic [DATA_W-1:0] mem_wdata
);

    // Two-way select between training and controller sources.
    always_comb begin
        if (own_io) begin
            mem_addr  = TRAIN_ADDR;
            mem_wr    = arm;
            mem_rd    = arm;
            mem_wdata = PATTERN;
        end else begin
            mem_addr  = ctl_addr;
            mem_wr    = ctl_wr;
            mem_rd    = ctl_rd;
            mem_wdata = ctl_wdata;
        end
    end

endmodule

// File: rtl/rdlat_trainer.sv
// Module: rdlat_trainer (top)
// Start-up read-latency training for a source-synchronous SRAM read path:
// takes over the memory I/O, pauses the controller, sequences pointer
// alignment, measures round-trip latency and issues the pointer offset.
// Assumes: rd_data is already in the system clock domain; TARGET_LAT < TIMEOUT.
module rdlat_trainer #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int TIMEOUT    = 64,
    parameter int TARGET_LAT = 12,
    parameter int BLANK      = 2,
    parameter logic [ADDR_W-1:0] TRAIN_ADDR = 8'h5A,
    parameter logic [DATA_W-1:0] PATTERN    = 16'hA5C3,
    localparam int LAT_W     = $clog2(TIMEOUT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dll_locked,
    input  logic [ADDR_W-1:0] ctl_addr,
    input  logic              ctl_wr,
    input  logic              ctl_rd,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              ctl_pause,
    output logic              rd_ptr_align,
    output logic              wr_ptr_rst,
    output logic              adj_vld,
    output logic [LAT_W-1:0]  adj_off,
    output logic              trn_busy,
    output logic              trn_done,
    output logic              trn_fail,
    output logic [LAT_W-1:0]  trn_lat
);

    logic             own_io, arm, measuring, hit, expire;
    logic [LAT_W-1:0] count;

    rdlat_meter #(
        .DATA_W(DATA_W), .TIMEOUT(TIMEOUT), .BLANK(BLANK), .PATTERN(PATTERN)
    ) u_meter (
        .clk(clk), .rst_n(rst_n), .arm(arm), .measuring(measuring),
        .rd_data(rd_data), .hit(hit), .expire(expire), .count(count)
    );

    rdlat_seq #(
        .TIMEOUT(TIMEOUT), .TARGET_LAT(TARGET_LAT)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .dll_locked(dll_locked),
        .hit(hit), .expire(expire), .count(count),
        .own_io(own_io), .arm(arm), .measuring(measuring),
        .rd_ptr_align(rd_ptr_align), .wr_ptr_rst(wr_ptr_rst),
        .adj_vld(adj_vld), .adj_off(adj_off),
        .trn_done(trn_done), .trn_fail(trn_fail), .trn_lat(trn_lat)
    );

    rdlat_iomux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TRAIN_ADDR(TRAIN_ADDR), .PATTERN(PATTERN)
    ) u_iomux (
        .own_io(own_io), .arm(arm),
        .ctl_addr(ctl_addr), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd), .ctl_wdata(ctl_wdata),
        .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_wdata(mem_wdata)
    );

    // Status and pause follow I/O ownership.
    always_comb begin
        ctl_pause = own_io;
        trn_busy  = own_io;
    end

    // R2
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_pause |-> (mem_addr == ctl_addr && mem_wr == ctl_wr && mem_rd == ctl_rd));

    // R3
    train_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_pause |-> (mem_addr == TRAIN_ADDR));

    // R6
    pattern_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_pause && mem_wr) |-> (mem_rd && mem_wdata == PATTERN));

    // R6
    single_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_pause && mem_wr) |=> !mem_wr);

endmodule

// File: tb/rdlat_trainer_bench.sv
module rdlat_trainer_bench;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int TMO = 64;
    localparam int TGT = 12;
    localparam int BLK = 2;
    localparam int LW = $clog2(TMO + 1);
    localparam logic [AW-1:0] TADDR = 8'h5A;
    localparam logic [DW-1:0] PAT   = 16'hA5C3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic dll_locked = 1'b0;
    logic [AW-1:0] ctl_addr = 8'h33;
    logic ctl_wr = 1'b1;
    logic ctl_rd = 1'b1;
    logic [DW-1:0] ctl_wdata = 16'h1234;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] mem_addr;
    logic mem_wr, mem_rd;
    logic [DW-1:0] mem_wdata;
    logic ctl_pause, rd_ptr_align, wr_ptr_rst, adj_vld;
    logic [LW-1:0] adj_off, trn_lat;
    logic trn_busy, trn_done, trn_fail;

    int total = 0;
    int bad = 0;
    int delay = 1;
    bit poison = 1'b0;
    logic [7:0] since = 8'd0;

    always #10 clk = ~clk;

    rdlat_trainer u_rdlat_trainer (
        .clk(clk), .rst_n(rst_n), .start(start), .dll_locked(dll_locked),
        .ctl_addr(ctl_addr), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd), .ctl_wdata(ctl_wdata),
        .rd_data(rd_data), .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd),
        .mem_wdata(mem_wdata), .ctl_pause(ctl_pause), .rd_ptr_align(rd_ptr_align),
        .wr_ptr_rst(wr_ptr_rst), .adj_vld(adj_vld), .adj_off(adj_off),
        .trn_busy(trn_busy), .trn_done(trn_done), .trn_fail(trn_fail), .trn_lat(trn_lat)
    );

    // Memory round-trip model: returns the pattern `delay` edges after a
    // write+read of the pattern to the training address.
    always @(posedge clk) begin
        if (ctl_pause && mem_wr && mem_rd && mem_addr == TADDR && mem_wdata == PAT)
            since <= 8'd1;
        else if (since != 8'd0 && since != 8'd255)
            since <= since + 8'd1;
    end

    always_comb begin
        if (since != 8'd0 && int'(since) == delay) rd_data = PAT;
        else if (poison && since >= 8'd1 && int'(since) <= BLK) rd_data = PAT;
        else rd_data = ~PAT;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_case(input int d, input bit poi, input int dll_dly, input bit extra_start);
        int cyc = 0;
        int align_n = 0, wr_n = 0, cmd_n = 0, adj_n = 0;
        int align_at = -1, wr_at = -1;
        int addr_bad = 0, pause_bad = 0;
        bit pass_exp;
        int lat_exp;
        bit fin = 1'b0;
        delay = d;
        poison = poi;
        dll_locked = (dll_dly == 0);
        @(negedge clk);
        start = 1'b1;
        while (!fin && cyc < 300) begin
            @(negedge clk);
            cyc++;
            start = (extra_start && cyc == 6);
            if (cyc == dll_dly) dll_locked = 1'b1;
            if (rd_ptr_align) begin align_n++; align_at = cyc; end
            if (wr_ptr_rst) begin wr_n++; wr_at = cyc; end
            if (trn_busy) begin
                if (mem_addr != TADDR) addr_bad++;
                if (!ctl_pause) pause_bad++;
                if (mem_wr && mem_rd && mem_addr == TADDR && mem_wdata == PAT) cmd_n++;
            end
            if (adj_vld) adj_n++;
            if (trn_done || trn_fail) fin = 1'b1;
        end
        pass_exp = (d > BLK) && (d <= TGT);
        lat_exp  = (d > BLK && d <= TMO) ? d : 0;
        // R3 busy window owns the address and pauses the controller
        check(addr_bad == 0 && pause_bad == 0, "R3", addr_bad + pause_bad, 0);
        // R4 alignment strictly after lock sampled
        check(align_at > dll_dly, "R4", align_at, dll_dly + 1);
        // R5 one align, one reset, reset right after align
        check(align_n == 1 && wr_n == 1 && wr_at == align_at + 1, "R5", wr_at, align_at + 1);
        // R6 single write/read of the pattern (R10 when a second start was sent)
        check(cmd_n == 1, extra_start ? "R10" : "R6", cmd_n, 1);
        // R7 measured latency
        check(int'(trn_lat) == lat_exp, "R7", trn_lat, lat_exp);
        if (pass_exp) begin
            // R8 done with offset and an adjust strobe in the first done cycle
            check(trn_done && !trn_fail, "R8", trn_done, 1);
            check(int'(adj_off) == TGT - d && adj_vld, "R8", adj_off, TGT - d);
        end else begin
            // R9 fail, no adjust
            check(trn_fail && !trn_done && adj_n == 0, "R9", trn_fail, 1);
        end
        @(negedge clk);
        // R8 adjust strobe is one cycle
        check(!adj_vld, "R8", adj_vld, 0);
        // R2 controller lines pass through after training
        ctl_addr = 8'(d * 7);
        ctl_wdata = 16'(d * 257);
        ctl_wr = d[0];
        ctl_rd = d[1];
        #1;
        check(mem_addr == ctl_addr && mem_wdata == ctl_wdata && mem_wr == ctl_wr
              && mem_rd == ctl_rd && !ctl_pause, "R2", mem_addr, ctl_addr);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!trn_busy && !trn_done && !trn_fail && !ctl_pause && !rd_ptr_align
              && !wr_ptr_rst && !adj_vld && trn_lat == '0, "R1", trn_busy, 0);
        check(mem_addr == ctl_addr && mem_wr == ctl_wr && mem_wdata == ctl_wdata, "R2",
              mem_addr, ctl_addr);
        // R4 training waits on a low lock
        dll_locked = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (8) begin
            @(negedge clk);
            check(!rd_ptr_align && trn_busy && ctl_pause, "R4", rd_ptr_align, 0);
        end
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        // Sweep of round-trip delays across all regions
        for (int d = 1; d <= 70; d++) begin
            run_case(d, d[0], (d % 4) * 3, d == 10);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule